// File: doc/BRIEF.md
# Signed Sample Gain Calibrator

This block applies a programmable calibration gain to a stream of signed converter samples. Each sample is a 20-bit two's-complement word. The block multiplies it by one plus a signed twelve-bit fraction, so the correction covers roughly half of the sample's value in either direction. The product is kept at full width, rounded back to sample resolution and limited to the converter's clamp codes. Downstream logic sees the same value range that it would see without calibration.

The sample path has a valid strobe. The scaled result appears with its own valid strobe exactly one clock later. A separate write port loads the gain word. A newly written gain applies to samples strobed after the write cycle, and an output sample is always computed with one gain word from start to finish.

Top module: `sample_gain_scaler`

## Requirements
- R1: While reset is asserted and until the first sample is strobed after release, `out_valid` is 0 and `out_sample` is 0. The gain word resets to 0.
- R2: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high, giving a fixed latency of one clock.
- R3: With gain word 0, a strobed input inside the clamp range appears unchanged at the output.
- R4: The output is the product x·(4096+G) divided by 4096, where x is the signed input and G is the gain read as twelve-bit two's complement. The quotient is rounded to the nearest integer, and exact halves round away from zero.
- R5: The output never leaves the range −262144 to +262144. A result beyond either limit is replaced by that limit.
- R6: A gain write in cycle t (`gain_wr` high) scales only samples strobed in later cycles. A sample strobed in cycle t itself uses the gain held before the write.
- R7: In a cycle that follows a cycle without `in_valid`, `out_sample` keeps its previous value.
- R8: Gain code 0x800 means −2048, which gives a factor of exactly one half. Gain code 0x7FF means +2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| gain_wr | input | 1 | Gain word write strobe |
| gain_wdata | input | 12 | Gain word, two's complement |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 20 | Input sample, two's complement |
| out_valid | output | 1 | Scaled sample strobe |
| out_sample | output | 20 | Scaled, rounded and limited sample |

## Verification
Every computation path ends in one output register, so a wrong gain word, a rounding slip or a missing limit shows up at `out_sample` in the cycle after the affected sample is strobed. A corrupted valid pipeline shows up at `out_valid` one cycle after the strobe. A gain register that updates at the wrong moment changes the first sample after the write, so the bench puts a write and a strobe in the same cycle and compares every output against a behavioural model on every clock. Halves of both signs, both clamp limits and the extreme gain codes are driven on purpose, because rounding and limiting faults only appear at those values.

// File: rtl/gain_scaler_pkg.sv
package gain_scaler_pkg;
  parameter int SAMPLE_W = 20;
  parameter int GAIN_W   = 12;
  parameter int FRAC_W   = 12;
  parameter int PROD_W   = SAMPLE_W + GAIN_W + 2;
  parameter int LIMIT    = 2 ** (SAMPLE_W - 2);

  typedef logic signed [PROD_W-1:0] wide_t;
endpackage

// File: rtl/gain_word_reg.sv
module gain_word_reg
  import gain_scaler_pkg::*;
#(
  parameter int GW = GAIN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [GW-1:0] wr_data,
  output logic [GW-1:0] gain_q
);
  logic [GW-1:0] gain_d;

  always_comb begin
    gain_d = gain_q;
    if (wr_en) gain_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gain_q <= '0;
    else        gain_q <= gain_d;
  end

  // R6: the gain word only moves when a write is strobed
  a_r6_gain_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(gain_q));
endmodule

// File: rtl/gain_mac_round.sv
module gain_mac_round
  import gain_scaler_pkg::*;
(
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [GAIN_W-1:0]   gain,
  output wide_t               rounded
);
  localparam int EXT_S = PROD_W - SAMPLE_W;
  localparam int EXT_G = PROD_W - GAIN_W;
  localparam wide_t UNITY = wide_t'(1) <<< FRAC_W;
  localparam wide_t HALF  = wide_t'(1) <<< (FRAC_W - 1);

  wide_t x_ext, factor, prod, mag, rmag;
  logic  neg;

  always_comb begin
    x_ext  = {{EXT_S{sample[SAMPLE_W-1]}}, sample};
    factor = UNITY + {{EXT_G{gain[GAIN_W-1]}}, gain};
    prod   = x_ext * factor;
    neg    = prod[PROD_W-1];
    mag    = neg ? -prod : prod;
    rmag   = (mag + HALF) >>> FRAC_W;
    rounded = neg ? -rmag : rmag;
  end
endmodule

// File: rtl/gain_clamp_reg.sv
module gain_clamp_reg
  import gain_scaler_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  wide_t               value,
  output logic                vld_q,
  output logic [SAMPLE_W-1:0] data_q
);
  localparam wide_t POS_LIM = wide_t'(LIMIT);
  localparam wide_t NEG_LIM = -POS_LIM;

  wide_t               limited;
  logic [SAMPLE_W-1:0] data_d;

  always_comb begin
    if (value > POS_LIM)      limited = POS_LIM;
    else if (value < NEG_LIM) limited = NEG_LIM;
    else                      limited = value;
    data_d = en ? limited[SAMPLE_W-1:0] : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q  <= en;
      data_q <= data_d;
    end
  end

  // R5: registered result stays within the clamp codes
  a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(data_q) <= $signed(POS_LIM[SAMPLE_W-1:0])) &&
    ($signed(data_q) >= $signed(NEG_LIM[SAMPLE_W-1:0])));
endmodule

// File: rtl/sample_gain_scaler.sv
module sample_gain_scaler
  import gain_scaler_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                gain_wr,
  input  logic [GAIN_W-1:0]   gain_wdata,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_sample
);
  logic [1:0]        rst_sync;
  logic              rst_core_n;
  logic [GAIN_W-1:0] gain_act;
  wide_t             rounded;
  logic              started;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  gain_word_reg #(.GW(GAIN_W)) u_gain (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (gain_wr),
    .wr_data (gain_wdata),
    .gain_q  (gain_act)
  );

  gain_mac_round u_mac (
    .sample  (in_sample),
    .gain    (gain_act),
    .rounded (rounded)
  );

  gain_clamp_reg u_clamp (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .en     (in_valid),
    .value  (rounded),
    .vld_q  (out_valid),
    .data_q (out_sample)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) started <= 1'b0;
    else             started <= 1'b1;
  end

  // R2: strobe emerges exactly one clock after the input strobe
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_core_n)
    started |-> (out_valid == $past(in_valid)));

  // R7: output word holds across idle cycles
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_core_n)
    (started && !$past(in_valid)) |-> $stable(out_sample));

  // R3: zero gain with an in-range input passes the sample through
  a_r3_unity: assert property (@(posedge clk) disable iff (!rst_core_n)
    (in_valid && gain_act == '0 &&
     $signed(in_sample) <= $signed(SAMPLE_W'(LIMIT)) &&
     $signed(in_sample) >= -$signed(SAMPLE_W'(LIMIT)))
    |=> (out_sample == $past(in_sample)));
endmodule

// File: tb/test_sample_gain_scaler.sv
module test_sample_gain_scaler;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        gain_wr;
  logic [11:0] gain_wdata;
  logic        in_valid;
  logic [19:0] in_sample;
  logic        out_valid;
  logic [19:0] out_sample;

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";
  bit    done = 1'b0;

  longint gain_m = 0;
  longint exp_data = 0;
  bit     exp_valid = 1'b0;

  always #2 clk = ~clk;

  sample_gain_scaler i_sample_gain_scaler (
    .clk(clk), .rst_n(rst_n), .gain_wr(gain_wr), .gain_wdata(gain_wdata),
    .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  function automatic longint scale(longint x, longint g);
    longint p, r;
    p = x * (4096 + g);
    if (p >= 0) r = (p + 2048) / 4096;
    else        r = -((-p + 2048) / 4096);
    if (r > 262144)  r = 262144;
    if (r < -262144) r = -262144;
    return r;
  endfunction

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_valid <= 1'b0;
      exp_data  <= 0;
      gain_m    <= 0;
    end else begin
      exp_valid <= in_valid;
      if (in_valid)
        exp_data <= scale(longint'($signed(in_sample)), gain_m);
      if (gain_wr)
        gain_m <= longint'($signed(gain_wdata));
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (out_valid !== exp_valid) begin
        errors++;
        $display("FAIL R2 out_valid actual=%0b expected=%0b", out_valid, exp_valid);
      end
      checks++;
      if (longint'($signed(out_sample)) != exp_data) begin
        errors++;
        $display("FAIL %s out_sample actual=%0d expected=%0d", tag,
                 $signed(out_sample), exp_data);
      end
    end
  end

  task automatic step(bit v, int x, bit w, int g);
    @(posedge clk);
    #1;
    in_valid   = v;
    in_sample  = 20'(x);
    gain_wr    = w;
    gain_wdata = 12'(g);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0, 0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0; gain_wr = 1'b0; gain_wdata = '0;
    fork
      begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(4);
        // R1: reset state checked by the per-cycle compare
        tag = "R3";
        step(1, 0, 0, 0); step(1, 165151, 0, 0); step(1, -165151, 0, 0);
        step(1, 262144, 0, 0); step(1, -262144, 0, 0); step(1, 1, 0, 0);
        tag = "R7";
        step(0, 12345, 0, 0); idle(3);
        tag = "R8";
        step(0, 0, 1, 'h800);
        step(1, 1, 0, 0); step(1, -1, 0, 0); step(1, 3, 0, 0); step(1, -3, 0, 0);
        step(1, 100001, 0, 0);
        tag = "R5";
        step(0, 0, 1, 'h7FF);
        step(1, 262144, 0, 0); step(1, -262144, 0, 0); step(1, 165151, 0, 0);
        step(1, -165151, 0, 0); step(1, 200000, 0, 0);
        tag = "R6";
        step(1, 50000, 1, 'h801);
        step(1, 50000, 0, 0);
        step(1, -70000, 1, 'h123);
        step(1, -70000, 0, 0);
        tag = "R4";
        for (int k = 0; k < 400; k++) begin
          int x;
          x = int'($urandom_range(0, 524288)) - 262144;
          step((k % 5) != 3, x, (k % 7) == 0, int'($urandom_range(0, 4095)));
        end
        tag = "R7";
        idle(4);
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog expired");
          done = 1'b1;
        end
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule